// File: doc/BRIEF.md
# Repeated-Addition Sequential Multiplier

This block multiplies a signed two's-complement multiplicand by a non-negative integer multiplier. It adds the multiplicand into a double-width accumulator once per unit of the multiplier and counts a copy of the multiplier down by one each step. A small controller with three states (idle, run, finish) sequences a datapath through two internal signals. `calc` tells the datapath to compute rather than load. `done` tells the controller that the count has reached zero.

A request is made by pulling the active-low start input low while the block is idle. The operands are taken on that same clock edge. The block then spends one cycle per unit of the multiplier plus one cycle to detect zero, so the latency depends on the operand. Once the product is ready, the completion flag stays high and the product stays frozen until start goes high again. The product output keeps its value until the next request completes.

Top module: `rep_add_mul`

## Requirements
- R1: After reset, `complete_o` is 0 and `product_o` is 0.
- R2: While idle, the block stays idle as long as `start_ni` is sampled high; `complete_o` stays 0 and `product_o` keeps its last value.
- R3: The operands are captured on the clock edge at which `start_ni` is sampled low in idle; changes on `mcand_i` and `mplier_i` after that edge do not affect the result.
- R4: If start is sampled low at edge k with multiplier value b, `complete_o` is 0 after edges k through k+b and rises after edge k+b+1.
- R5: `product_o` equals the multiplicand sign-extended to 2*OPW bits times the zero-extended multiplier, modulo 2^(2*OPW); for example, with 8-bit operands, 8'hFE times 8'h03 gives 16'hFFFA.
- R6: A multiplier of 0 gives a product of 0, and `complete_o` rises after edge k+1.
- R7: While `complete_o` is 1 and `start_ni` is low, `complete_o` stays 1 and `product_o` does not change.
- R8: When `start_ni` is sampled high while `complete_o` is 1, `complete_o` falls on that edge and `product_o` keeps its value.
- R9: Extreme operands (most negative multiplicand, all-ones multiplier) give the exact full-width product with no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_ni | input | 1 | Start request, active low |
| mcand_i | input | OPW | Multiplicand, two's complement |
| mplier_i | input | OPW | Multiplier, unsigned integer |
| product_o | output | 2*OPW | Product, two's complement |
| complete_o | output | 1 | Result ready flag |

## Verification
The bench applies directed operand pairs and a run of random ones. The directed pairs are a negative multiplicand against a small multiplier, a zero multiplier, and the most negative multiplicand against the all-ones multiplier. These separate sign-extension faults, faults in detecting a zero count, and faults in accumulator width. Each request is made either with a one-cycle start pulse or with start held low through finish. This separates the finish-hold behaviour from a return to idle. The operand inputs are scrambled during each run, which exposes any datapath that reads the inputs after capture. A behavioural model built from latency and product arithmetic is compared with both outputs on every cycle.

// File: rtl/rep_add_mul_pkg.sv
package rep_add_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mul_state_e;
endpackage

// File: rtl/rep_mul_ctrl.sv
module rep_mul_ctrl
  import rep_add_mul_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_ni,
  input  logic done_i,
  output logic calc_o,
  output logic complete_o
);
  mul_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (!start_ni) state_d = ST_RUN;
      ST_RUN:  if (done_i)    state_d = ST_FIN;
      ST_FIN:  if (start_ni)  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign calc_o     = (state_q == ST_RUN);
  assign complete_o = (state_q == ST_FIN);
endmodule

// File: rtl/rep_mul_dp.sv
module rep_mul_dp #(
  parameter int unsigned OPW = 8,
  localparam int unsigned PW = 2 * OPW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           calc_i,
  input  logic [OPW-1:0] mcand_i,
  input  logic [OPW-1:0] mplier_i,
  output logic           done_o,
  output logic [PW-1:0]  product_o
);
  logic [PW-1:0]  mcand_q;
  logic [OPW-1:0] mplier_q;
  logic [PW-1:0]  acc_q;
  logic [PW-1:0]  prod_q;
  logic           zero;

  assign zero   = (mplier_q == '0);
  assign done_o = calc_i && zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else if (!calc_i) begin
      // sign-extend multiplicand to the full product width
      mcand_q  <= {{OPW{mcand_i[OPW-1]}}, mcand_i};
      mplier_q <= mplier_i;
      acc_q    <= '0;
    end else if (!zero) begin
      acc_q    <= acc_q + mcand_q;
      mplier_q <= mplier_q - 1'b1;
    end
  end

  // result register: written only when the count is exhausted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prod_q <= '0;
    else if (done_o) prod_q <= acc_q;
  end

  assign product_o = prod_q;
endmodule

// File: rtl/rep_add_mul.sv
module rep_add_mul #(
  parameter int unsigned OPW = 8,
  localparam int unsigned PW = 2 * OPW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_ni,
  input  logic [OPW-1:0] mcand_i,
  input  logic [OPW-1:0] mplier_i,
  output logic [PW-1:0]  product_o,
  output logic           complete_o
);
  logic calc;
  logic done;

  rep_mul_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_ni  (start_ni),
    .done_i    (done),
    .calc_o    (calc),
    .complete_o(complete_o)
  );

  rep_mul_dp #(.OPW(OPW)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .calc_i   (calc),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .done_o   (done),
    .product_o(product_o)
  );
endmodule

// File: rtl/rep_add_mul_chk.sv
module rep_add_mul_chk #(
  parameter int unsigned PW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_ni,
  input logic          calc,
  input logic          done,
  input logic [PW-1:0] product_o,
  input logic          complete_o
);
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!calc && !complete_o && start_ni) |=> (!calc && !complete_o));

  // R4
  run_continue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (calc && !done) |=> (calc && !complete_o));

  // R4
  done_to_fin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (complete_o && !calc));

  // R7
  fin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (complete_o && !start_ni) |=> complete_o);

  // R7
  prod_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete_o |=> $stable(product_o));

  // R8
  fin_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (complete_o && start_ni) |=> (!complete_o && !calc));

  // R2
  state_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({calc, complete_o}));
endmodule

bind rep_add_mul rep_add_mul_chk #(.PW(PW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_ni  (start_ni),
  .calc      (calc),
  .done      (done),
  .product_o (product_o),
  .complete_o(complete_o)
);

// File: tb/rep_add_mul_tb_top.sv
module rep_add_mul_tb_top;
  localparam int unsigned OPW = 8;
  localparam int unsigned PW  = 2 * OPW;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_ni = 1'b1;
  logic [OPW-1:0] mcand_i = '0;
  logic [OPW-1:0] mplier_i = '0;
  logic [PW-1:0]  product_o;
  logic           complete_o;

  int n_chk = 0;
  int n_err = 0;
  bit done_all = 0;
  string cur_req = "R1";

  always #4 clk_i = ~clk_i;  // 125 MHz

  rep_add_mul #(.OPW(OPW)) dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_ni  (start_ni),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .product_o (product_o),
    .complete_o(complete_o)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 run, 2 finish
  int            m_mode = 0;
  int            m_rem  = 0;
  logic [PW-1:0] m_next = '0;
  logic [PW-1:0] m_prod = '0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_rem = 0; m_prod = '0; m_next = '0;
    end else begin
      case (m_mode)
        0: if (!start_ni) begin
             m_mode = 1;
             m_rem  = int'(mplier_i);
             m_next = PW'(longint'($signed(mcand_i)) * longint'(mplier_i));
           end
        1: if (m_rem == 0) begin m_mode = 2; m_prod = m_next; end
           else m_rem = m_rem - 1;
        default: if (start_ni) m_mode = 0;
      endcase
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done_all) begin
      chk(complete_o == (m_mode == 2), cur_req, "complete_o vs model",
          longint'(complete_o), longint'(m_mode == 2));
      chk(product_o == m_prod, cur_req, "product_o vs model",
          longint'(product_o), longint'(m_prod));
    end
  end

  task automatic finish_run();
    done_all = 1;
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  endtask

  task automatic run_op(logic [OPW-1:0] a, logic [OPW-1:0] b, bit hold, string req);
    int n;
    logic [PW-1:0] e;
    logic [PW-1:0] p;
    e = PW'(longint'($signed(a)) * longint'(b));
    cur_req = req;
    @(negedge clk_i);
    mcand_i = a; mplier_i = b; start_ni = 1'b0;
    @(negedge clk_i);
    mcand_i = OPW'($urandom); mplier_i = OPW'($urandom);  // R3: ignored after capture
    if (!hold) start_ni = 1'b1;
    n = 0;
    while (!complete_o && n < 2000) begin n++; @(negedge clk_i); end
    // R4 latency: b+1 cycles low after the capture edge
    chk(n == int'(b) + 1, "R4", "cycles before complete", longint'(n), longint'(b) + 1);
    // R3 R5 product
    chk(product_o == e, req, "product", longint'(product_o), longint'(e));
    p = product_o;
    if (hold) begin
      repeat (3) @(negedge clk_i);
      // R7
      chk(complete_o == 1'b1, "R7", "complete held", longint'(complete_o), 1);
      chk(product_o == p, "R7", "product held", longint'(product_o), longint'(p));
      start_ni = 1'b1;
    end
    @(negedge clk_i);
    // R8
    chk(complete_o == 1'b0, "R8", "complete after start high", longint'(complete_o), 0);
    chk(product_o == p, "R8", "product kept", longint'(product_o), longint'(p));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    chk(complete_o == 1'b0, "R1", "complete in reset", longint'(complete_o), 0);
    chk(product_o == '0, "R1", "product in reset", longint'(product_o), 0);
    rst_ni = 1'b1;
    cur_req = "R2";
    repeat (5) @(negedge clk_i);
    // R2
    chk(complete_o == 1'b0, "R2", "idle without start", longint'(complete_o), 0);
    run_op(8'hFE, 8'h03, 1'b0, "R5");
    chk(product_o == 16'hFFFA, "R5", "FE x 03", longint'(product_o), 16'hFFFA);
    cur_req = "R2";
    mcand_i = 8'h55; mplier_i = 8'h07;
    repeat (4) @(negedge clk_i);
    chk(product_o == 16'hFFFA, "R2", "product kept in idle", longint'(product_o), 16'hFFFA);
    run_op(8'h35, 8'h00, 1'b1, "R6");
    chk(product_o == '0, "R6", "zero multiplier", longint'(product_o), 0);
    run_op(8'h80, 8'hFF, 1'b1, "R9");
    chk(product_o == 16'h8080, "R9", "80 x FF", longint'(product_o), 16'h8080);
    run_op(8'h7F, 8'h05, 1'b0, "R3");
    for (int i = 0; i < 24; i++)
      run_op(OPW'($urandom), OPW'($urandom % 40), i[0], "R5");
    repeat (2) @(negedge clk_i);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule